// File: doc/BRIEF.md
# Programmable I2C Serial Clock Rate Generator

This block derives the serial clock timing of an I2C controller from the system clock. A 6-bit divider code picks the timing. The code splits into two 3-bit indices, and each index selects a pair of small constants from a fixed table. From these four constants the block computes a full SCL period and an SDA hold delay, both counted in system clocks. It needs no division at run time.

While `enable` is high, the block runs periods back to back. Each period starts with a high phase of half the period and ends with a low phase of the same length. The block outputs the phase level and three single-cycle strobes: one at each rising SCL edge, one at each falling SCL edge, and one at the point inside the low phase where a byte shifter may change SDA. A new code is taken only at a period boundary. While `enable` is low, the timing is parked with SCL high.

Top module: `sclRateGen`

## Requirements
- R1: While `rstN` is low, and on every cycle after a cycle with `enable` low, `sclPhase` is 1 and `sclRise`, `sclFall` and `sdaStrobe` are 0.
- R2: Code bits {5,1,0} form index J, with bit 5 as the MSB. J selects (sclTap, sdaTap) from: J0 (9,3), J1 (10,3), J2 (12,4), J3 (15,4), J4 (5,1), J5 (6,1), J6 (7,2), J7 (8,2).
- R3: Code bits {4,3,2} form index I, with bit 4 as the MSB. I selects (lead, step) from: I0 (4,1), I1 (4,2), I2 (6,4), I3 (6,8), I4 (14,16), I5 (30,32), I6 (62,64), I7 (126,128).
- R4: The period is P = 2*(lead + (sclTap-1)*step + 2) system clocks. Code 0x00 gives P = 28, and code 0x3F gives P = 2048.
- R5: Take the first cycle after `enable` is sampled high as cycle 0. `sclPhase` is 1 in that cycle and for the first P/2 cycles of every period. It is 0 for the remaining P/2 cycles.
- R6: `sdaStrobe` pulses for one cycle, D = lead + (sdaTap-1)*step + 3 cycles after the `sclFall` cycle. Code 0x00 gives D = 9, and code 0x3F gives D = 257. It lies within the low phase.
- R7: `sclFall` is 1 exactly in the first low cycle of each period. `sclRise` is 1 exactly in the first cycle of every period after the first, so the first rise comes at cycle P.
- R8: A code change inside a period leaves that period unchanged. The following period uses the new code.
- R9: At most one of `sclRise`, `sclFall`, `sdaStrobe` is 1 in any cycle.
- R10: Dropping `enable` during a period abandons it. Raising `enable` again starts a fresh period at cycle 0 with the high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the SCL timing while high |
| divCode | input | 6 | Divider code, indices J = {5,1,0}, I = {4,3,2} |
| sclPhase | output | 1 | 1 during the SCL high phase or when idle |
| sclRise | output | 1 | One-cycle strobe at a rising SCL edge |
| sclFall | output | 1 | One-cycle strobe at a falling SCL edge |
| sdaStrobe | output | 1 | One-cycle strobe at the SDA change point |

## Verification
The directed codes include the two table corners, 0x00 and 0x3F. They also include codes that move only one index from zero, which separates a wrong bit-to-index mapping of J from one of I: the 0x20 code and the 0x04 code differ only in which index is nonzero. Random codes then cover the rest of the table. For each code the bench measures the fall, SDA and rise cycles and compares them with period and hold values computed from the formulas. A code change in the middle of a period shows whether the new code is picked up at the boundary or too early. Dropping `enable` during the low phase shows that the block parks with SCL high and restarts cleanly.

// File: rtl/sclRatePkg.sv
package sclRatePkg;
  // Control-to-datapath requests, one cycle each
  typedef struct packed {
    logic clear;   // park the counter at zero and take the current code
    logic wrap;    // period boundary: restart count and take the current code
  } ctlStrobe_t;
endpackage

// File: rtl/sclTimingPath.sv
module sclTimingPath #(
  parameter int CNT_W = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [5:0]             divCode,
  input  sclRatePkg::ctlStrobe_t ctl,
  output logic                   atStart,
  output logic                   atEnd,
  output logic                   atHalf,
  output logic                   atSda,
  output logic                   inHigh
);
  // SCL/SDA tap pair picked by index J
  function automatic logic [15:0] tapPair(input logic [2:0] j);
    case (j)
      3'd0: tapPair = {8'd9, 8'd3};
      3'd1: tapPair = {8'd10, 8'd3};
      3'd2: tapPair = {8'd12, 8'd4};
      3'd3: tapPair = {8'd15, 8'd4};
      3'd4: tapPair = {8'd5, 8'd1};
      3'd5: tapPair = {8'd6, 8'd1};
      3'd6: tapPair = {8'd7, 8'd2};
      default: tapPair = {8'd8, 8'd2};
    endcase
  endfunction

  // Lead delay and tap step picked by index I
  function automatic logic [15:0] chainPair(input logic [2:0] i);
    case (i)
      3'd0: chainPair = {8'd4, 8'd1};
      3'd1: chainPair = {8'd4, 8'd2};
      3'd2: chainPair = {8'd6, 8'd4};
      3'd3: chainPair = {8'd6, 8'd8};
      3'd4: chainPair = {8'd14, 8'd16};
      3'd5: chainPair = {8'd30, 8'd32};
      3'd6: chainPair = {8'd62, 8'd64};
      default: chainPair = {8'd126, 8'd128};
    endcase
  endfunction

  logic [2:0]       idxJ, idxI;
  logic [7:0]       sclTap, sdaTap, lead, step;
  logic [CNT_W-1:0] halfNext, holdNext;
  logic [CNT_W-1:0] halfQ, holdQ, cnt;
  logic [CNT_W-1:0] lastCnt, sdaCnt;

  assign idxJ = {divCode[5], divCode[1], divCode[0]};
  assign idxI = divCode[4:2];
  assign {sclTap, sdaTap} = tapPair(idxJ);
  assign {lead, step}     = chainPair(idxI);

  // Half period = lead + (sclTap-1)*step + 2 ; full period is twice that
  assign halfNext = CNT_W'(lead) + CNT_W'(sclTap - 8'd1) * CNT_W'(step) + CNT_W'(2);
  assign holdNext = CNT_W'(lead) + CNT_W'(sdaTap - 8'd1) * CNT_W'(step) + CNT_W'(3);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      halfQ <= '0;
      holdQ <= '0;
    end else if (ctl.clear || ctl.wrap) begin
      cnt   <= '0;
      halfQ <= halfNext;
      holdQ <= holdNext;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign lastCnt = {halfQ[CNT_W-2:0], 1'b0} - CNT_W'(1);
  assign sdaCnt  = halfQ + holdQ;

  assign atStart = (cnt == '0);
  assign atEnd   = (cnt == lastCnt);
  assign atHalf  = (cnt == halfQ);
  assign atSda   = (cnt == sdaCnt);
  assign inHigh  = (cnt < halfQ);
endmodule

// File: rtl/sclPhaseCtl.sv
module sclPhaseCtl (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enable,
  input  logic                   atStart,
  input  logic                   atEnd,
  input  logic                   atHalf,
  input  logic                   atSda,
  input  logic                   inHigh,
  output sclRatePkg::ctlStrobe_t ctl,
  output logic                   sclPhase,
  output logic                   sclRise,
  output logic                   sclFall,
  output logic                   sdaStrobe
);
  logic running;   // counter is live this cycle
  logic wrapped;   // at least one period boundary since enable

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      wrapped <= 1'b0;
    end else begin
      running <= enable;
      if (!enable)
        wrapped <= 1'b0;
      else if (running && atEnd)
        wrapped <= 1'b1;
    end
  end

  always_comb begin
    ctl.clear = !enable || !running;
    ctl.wrap  = running && atEnd;
  end

  assign sclPhase  = !running || inHigh;
  assign sclFall   = running && atHalf;
  assign sdaStrobe = running && atSda;
  assign sclRise   = running && wrapped && atStart;
endmodule

// File: rtl/sclRateGen.sv
module sclRateGen #(
  parameter int CNT_W = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [5:0] divCode,
  output logic       sclPhase,
  output logic       sclRise,
  output logic       sclFall,
  output logic       sdaStrobe
);
  sclRatePkg::ctlStrobe_t ctl;
  logic atStart, atEnd, atHalf, atSda, inHigh;

  sclTimingPath #(.CNT_W(CNT_W)) i_path (
    .clk(clk), .rstN(rstN), .divCode(divCode), .ctl(ctl),
    .atStart(atStart), .atEnd(atEnd), .atHalf(atHalf), .atSda(atSda), .inHigh(inHigh)
  );

  sclPhaseCtl i_ctl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .atStart(atStart), .atEnd(atEnd), .atHalf(atHalf), .atSda(atSda), .inHigh(inHigh),
    .ctl(ctl), .sclPhase(sclPhase), .sclRise(sclRise), .sclFall(sclFall),
    .sdaStrobe(sdaStrobe)
  );
endmodule

// File: rtl/sclRateGenChecker.sv
module sclRateGenChecker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic sclPhase,
  input logic sclRise,
  input logic sclFall,
  input logic sdaStrobe
);
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (sclPhase && !sclRise && !sclFall && !sdaStrobe));

  p_fall_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    sclFall |-> (!sclPhase && $past(sclPhase)));

  p_rise_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    sclRise |-> (sclPhase && !$past(sclPhase)));

  p_sda_in_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    sdaStrobe |-> !sclPhase);

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sclRise, sclFall, sdaStrobe}));

  always_comb begin
    if (!rstN) begin
      a_reset_idle_r1: assert (sclPhase && !sclRise && !sclFall && !sdaStrobe);
    end
  end
endmodule

bind sclRateGen sclRateGenChecker i_checker (
  .clk(clk), .rstN(rstN), .enable(enable), .sclPhase(sclPhase),
  .sclRise(sclRise), .sclFall(sclFall), .sdaStrobe(sdaStrobe)
);

// File: tb/test_sclRateGen.sv
module test_sclRateGen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [5:0] divCode = 6'd0;
  logic sclPhase, sclRise, sclFall, sdaStrobe;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;   // 250 MHz

  sclRateGen i_sclRateGen (
    .clk(clk), .rstN(rstN), .enable(enable), .divCode(divCode),
    .sclPhase(sclPhase), .sclRise(sclRise), .sclFall(sclFall), .sdaStrobe(sdaStrobe)
  );

  // Expected timing from the requirement formulas
  function automatic int jTap(input int j, input bit sda);
    int scl[8] = '{9, 10, 12, 15, 5, 6, 7, 8};
    int sd[8]  = '{3, 3, 4, 4, 1, 1, 2, 2};
    return sda ? sd[j] : scl[j];
  endfunction
  function automatic int iVal(input int i, input bit isStep);
    int ld[8] = '{4, 4, 6, 6, 14, 30, 62, 126};
    int st[8] = '{1, 2, 4, 8, 16, 32, 64, 128};
    return isStep ? st[i] : ld[i];
  endfunction
  function automatic int expPeriod(input logic [5:0] c);
    int j = {c[5], c[1], c[0]};
    int i = c[4:2];
    return 2 * (iVal(i, 0) + (jTap(j, 0) - 1) * iVal(i, 1) + 2);
  endfunction
  function automatic int expHold(input logic [5:0] c);
    int j = {c[5], c[1], c[0]};
    int i = c[4:2];
    return iVal(i, 0) + (jTap(j, 1) - 1) * iVal(i, 1) + 3;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Run one period from a fresh enable; optionally switch code at cycle swAt
  task automatic runCode(input logic [5:0] c, input string req,
                         input int swAt, input logic [5:0] c2);
    int fT = -1, sT = -1, rT = -1, f2 = -1, r2 = -1;
    int startHigh = 0;
    int p = expPeriod(c), h = expHold(c);
    enable = 1'b0;
    divCode = c;
    repeat (2) @(posedge clk);
    #1 enable = 1'b1;
    @(posedge clk);
    for (int t = 0; t < 9000; t++) begin
      @(negedge clk);
      if (t == 0) startHigh = sclPhase;
      if (swAt >= 0 && t == swAt) divCode = c2;
      if (sclFall) begin if (fT < 0) fT = t; else if (f2 < 0) f2 = t; end
      if (sdaStrobe && sT < 0) sT = t;
      if (sclRise) begin
        if (rT < 0) rT = t; else if (r2 < 0) r2 = t;
        if (swAt < 0 || r2 >= 0) break;
      end
    end
    chk(req, "R5 high at cycle0", startHigh, 1);
    chk(req, "R5 fall cycle", fT, p / 2);
    chk(req, "R6 sda cycle", sT, p / 2 + h);
    chk(req, "R4/R7 first rise", rT, p);
    if (swAt >= 0) begin
      chk("R8", "second fall", f2, p + expPeriod(c2) / 2);
      chk("R8", "second rise", r2, p + expPeriod(c2));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset phase", sclPhase, 1);
    chk("R1", "reset strobes", {sclRise, sclFall, sdaStrobe}, 0);
    #1 rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "idle phase", sclPhase, 1);
    chk("R1", "idle strobes", {sclRise, sclFall, sdaStrobe}, 0);

    runCode(6'h00, "R4 corner 0x00", -1, 6'h00);
    runCode(6'h3F, "R4 corner 0x3F", -1, 6'h00);
    runCode(6'h20, "R2 J-bit5", -1, 6'h00);
    runCode(6'h02, "R2 J-bit1", -1, 6'h00);
    runCode(6'h01, "R2 J-bit0", -1, 6'h00);
    runCode(6'h04, "R3 I-bit2", -1, 6'h00);
    runCode(6'h10, "R3 I-bit4", -1, 6'h00);
    for (int k = 0; k < 8; k++) begin
      logic [5:0] rc = 6'($urandom);
      runCode(rc, "R2/R3 random", -1, 6'h00);
    end

    // R8: code switch inside first period
    runCode(6'h00, "R8 base", 5, 6'h21);
    runCode(6'h21, "R8 base rev", 3, 6'h00);

    // R10: drop enable in the low phase, then restart
    enable = 1'b0;
    divCode = 6'h00;
    repeat (2) @(posedge clk);
    #1 enable = 1'b1;
    repeat (21) @(posedge clk);
    @(negedge clk);
    chk("R10", "in low phase before drop", sclPhase, 0);
    enable = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R10", "parked phase", sclPhase, 1);
      chk("R10", "parked strobes", {sclRise, sclFall, sdaStrobe}, 0);
    end
    runCode(6'h00, "R10 restart", -1, 6'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule